// File: doc/BRIEF.md
# Priority interrupt request arbiter

This block sits between a set of interrupt-capable devices and a processor's control sequencer. Each of up to eight devices raises a request bit and is tagged with one of eight urgency levels, 0 being the least urgent and 7 the most. Every cycle the block finds the most urgent pending request and weighs its level against the level the processor is running at.

The processor pulses a boundary strobe once per instruction, after the store phase and before the next fetch. In that cycle only, the block records whether the program should be preempted. Preemption happens when the winning level is strictly greater than the running level. On the next clock edge it raises a one-cycle take pulse and latches the winning level and device index for the sequencer to use. Without a take, execution goes on to the next fetch and the latched winner is left unchanged.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While reset is low and in the first cycle after it, `take` is 0, `win_lvl` is 0 and `win_idx` is 0.
- R2: `take` is high only in the cycle after a rising clock edge at which `boundary` was high. Requests seen with `boundary` low never raise `take`.
- R3: The pending device chosen is the one whose 3-bit level is numerically greatest. Device i's level is `src_lvl[3*i+2:3*i]` and its request is `req[i]`.
- R4: When several pending devices share the greatest level, the one with the smallest index is chosen.
- R5: A boundary with a pending winner gives `take` = 1 only if the winner's level is strictly greater than `cur_lvl`. A winner at a level equal to or below `cur_lvl` gives `take` = 0.
- R6: A boundary with `req` all zero gives `take` = 0.
- R7: `win_lvl` and `win_idx` load the winner's level and index on the same edge that raises `take`, and hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 8 | Request bit per device, bit i is device i |
| src_lvl | input | 24 | Packed 3-bit levels, device i at bits 3*i+2:3*i |
| cur_lvl | input | 3 | Level the processor is running at |
| boundary | input | 1 | Instruction-boundary strobe, store done and fetch next |
| take | output | 1 | Registered one-cycle preempt pulse |
| win_lvl | output | 3 | Level of the last taken request |
| win_idx | output | 3 | Device index of the last taken request |

## Verification
A wrong winner inside the encoder chain shows up in `win_lvl` or `win_idx` one cycle after the boundary that accepts it. The bench sweeps every device, level and running level against a scan from the top level down. A faulty compare shows up as a missing or extra `take` one cycle after a boundary, at the equal-level edge in particular. A latch that updates when it should not shows up during the off-boundary cycles, when the outputs move without `take`.

// File: rtl/irq_arb_pkg.sv
// Package: shared defaults and helpers for the interrupt arbiter.
// Assumes: widths are small (device counts up to a few dozen).
package irq_arb_pkg;

    localparam int unsigned DEF_SRCS  = 8;
    localparam int unsigned DEF_LVL_W = 3;

    // Width of an index able to address n entries (at least one bit).
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/irq_win_find.sv
// Module: irq_win_find
// Finds the pending request with the greatest level, lowest index on ties.
// Assumes: purely combinational; levels packed LVL_W bits per device.
module irq_win_find
    import irq_arb_pkg::*;
#(
    parameter int unsigned N_SRC = DEF_SRCS,
    parameter int unsigned LVL_W = DEF_LVL_W,
    parameter int unsigned IDX_W = idx_bits(N_SRC)
) (
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC*LVL_W-1:0] src_lvl,
    output logic                   found,
    output logic [LVL_W-1:0]       best_lvl,
    output logic [IDX_W-1:0]       best_idx
);

    logic             stg_v [N_SRC+1];
    logic [LVL_W-1:0] stg_l [N_SRC+1];
    logic [IDX_W-1:0] stg_i [N_SRC+1];

    assign stg_v[0] = 1'b0;
    assign stg_l[0] = '0;
    assign stg_i[0] = '0;

    // One stage per device: a later device replaces only on a strictly greater level.
    for (genvar g = 0; g < N_SRC; g++) begin : g_stage
        logic [LVL_W-1:0] lvl_g;
        logic             wins;
        assign lvl_g = src_lvl[g*LVL_W +: LVL_W];
        assign wins  = req[g] && (!stg_v[g] || (lvl_g > stg_l[g]));
        assign stg_v[g+1] = stg_v[g] | req[g];
        assign stg_l[g+1] = wins ? lvl_g : stg_l[g];
        assign stg_i[g+1] = wins ? IDX_W'(g) : stg_i[g];
    end

    assign found    = stg_v[N_SRC];
    assign best_lvl = stg_l[N_SRC];
    assign best_idx = stg_i[N_SRC];

    // Cross-check the chain result against a pairwise comparison of all devices.
    logic chk_bad;
    always_comb begin
        chk_bad = 1'b0;
        if (found != (|req)) chk_bad = 1'b1;
        if (found && !req[best_idx]) chk_bad = 1'b1;
        for (int j = 0; j < int'(N_SRC); j++) begin
            if (found && req[j]) begin
                if (src_lvl[j*LVL_W +: LVL_W] > best_lvl) chk_bad = 1'b1;
                if ((src_lvl[j*LVL_W +: LVL_W] == best_lvl) && (j < int'(best_idx)))
                    chk_bad = 1'b1;
            end
        end
        // R3 R4
        win_order_chk: assert (!chk_bad) else $error("winner is not greatest level / lowest index");
    end

endmodule

// File: rtl/irq_preempt_gate.sv
// Module: irq_preempt_gate
// Decides whether the selected request may preempt the running program.
// Assumes: levels are unsigned, larger value is more urgent.
module irq_preempt_gate #(
    parameter int unsigned LVL_W = 3
) (
    input  logic             found,
    input  logic [LVL_W-1:0] best_lvl,
    input  logic [LVL_W-1:0] cur_lvl,
    output logic             grant
);

    // Strict comparison: an equal level never preempts.
    always_comb grant = found && (best_lvl > cur_lvl);

endmodule

// File: rtl/irq_prio_arbiter.sv
// Module: irq_prio_arbiter (top)
// Samples the preemption decision at the instruction boundary and issues
// a one-cycle take pulse with the winning level and device index.
// Assumes: boundary is high for one cycle per instruction; synchronous active-low reset.
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned N_SRC = DEF_SRCS,
    parameter int unsigned LVL_W = DEF_LVL_W,
    localparam int unsigned IDX_W = idx_bits(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC*LVL_W-1:0] src_lvl,
    input  logic [LVL_W-1:0]       cur_lvl,
    input  logic                   boundary,
    output logic                   take,
    output logic [LVL_W-1:0]       win_lvl,
    output logic [IDX_W-1:0]       win_idx
);

    logic             found;
    logic [LVL_W-1:0] best_lvl;
    logic [IDX_W-1:0] best_idx;
    logic             grant;

    irq_win_find #(
        .N_SRC (N_SRC),
        .LVL_W (LVL_W),
        .IDX_W (IDX_W)
    ) u_find (
        .req      (req),
        .src_lvl  (src_lvl),
        .found    (found),
        .best_lvl (best_lvl),
        .best_idx (best_idx)
    );

    irq_preempt_gate #(
        .LVL_W (LVL_W)
    ) u_gate (
        .found    (found),
        .best_lvl (best_lvl),
        .cur_lvl  (cur_lvl),
        .grant    (grant)
    );

    // Register the boundary decision and latch the winner when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take    <= 1'b0;
            win_lvl <= '0;
            win_idx <= '0;
        end else begin
            take <= boundary && grant;
            if (boundary && grant) begin
                win_lvl <= best_lvl;
                win_idx <= best_idx;
            end
        end
    end

    // R2
    take_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(boundary));

    // R5
    take_above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (win_lvl > $past(cur_lvl)));

    // R6
    idle_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && (req == '0)) |=> !take);

    // R7
    winner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> ($stable(win_lvl) && $stable(win_idx)));

endmodule

// File: tb/test_irq_prio_arbiter.sv
`timescale 1ns/1ps
module test_irq_prio_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req = '0;
    logic [23:0] src_lvl = '0;
    logic [2:0]  cur_lvl = '0;
    logic        boundary = 1'b0;
    logic        take;
    logic [2:0]  win_lvl;
    logic [2:0]  win_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [2:0] exp_lvl = '0;
    logic [2:0] exp_idx = '0;

    always #10 clk = ~clk;

    irq_prio_arbiter i_irq_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .src_lvl(src_lvl),
        .cur_lvl(cur_lvl), .boundary(boundary),
        .take(take), .win_lvl(win_lvl), .win_idx(win_idx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference: scan levels from most urgent downwards, devices from index 0 upwards.
    task automatic ref_pick(input logic [7:0] r, input logic [23:0] l,
                            output bit any, output int lv, output int ix, output int ties);
        any = 0; lv = 0; ix = 0; ties = 0;
        for (int lvl = 7; lvl >= 0 && !any; lvl--) begin
            for (int d = 0; d < 8; d++) begin
                if (r[d] && (int'(l[d*3 +: 3]) == lvl)) begin
                    if (!any) begin any = 1; lv = lvl; ix = d; end
                    ties++;
                end
            end
        end
    endtask

    // One boundary cycle, then checks one cycle later.
    task automatic step(input logic [7:0] r, input logic [23:0] l, input logic [2:0] c);
        bit any; int lv; int ix; int ties; bit exp_take;
        @(negedge clk);
        req = r; src_lvl = l; cur_lvl = c; boundary = 1'b1;
        ref_pick(r, l, any, lv, ix, ties);
        exp_take = any && (lv > int'(c));
        if (exp_take) begin exp_lvl = 3'(lv); exp_idx = 3'(ix); end
        @(negedge clk);
        boundary = 1'b0;
        if (!any) chk("R6 take with no request", int'(take), 0);
        else      chk("R5 take vs running level", int'(take), int'(exp_take));
        chk("R3 winner level", int'(win_lvl), int'(exp_lvl));
        if (ties > 1) chk("R4 tie lowest index", int'(win_idx), int'(exp_idx));
        else          chk("R3 winner index", int'(win_idx), int'(exp_idx));
        // Off-boundary cycle with new traffic must not fire or move the winner.
        req = 8'hFF; src_lvl = 24'hFFFFFF; cur_lvl = 3'd0;
        @(negedge clk);
        chk("R2 no take without boundary", int'(take), 0);
        chk("R7 winner level held", int'(win_lvl), int'(exp_lvl));
        chk("R7 winner index held", int'(win_idx), int'(exp_idx));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 take in reset", int'(take), 0);
        chk("R1 win_lvl in reset", int'(win_lvl), 0);
        chk("R1 win_idx in reset", int'(win_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 take after reset", int'(take), 0);
        chk("R1 win_idx after reset", int'(win_idx), 0);
        // Single device: every index x level x running level.
        for (int d = 0; d < 8; d++)
            for (int lv = 0; lv < 8; lv++)
                for (int c = 0; c < 8; c++)
                    step(8'(1 << d), 24'(lv) << (3 * d), 3'(c));
        // All devices at one level: tie goes to index 0, equal level never preempts.
        for (int lv = 0; lv < 8; lv++)
            for (int c = 0; c < 8; c++)
                step(8'hFF, {8{3'(lv)}}, 3'(c));
        // No requests at all.
        for (int c = 0; c < 8; c++) step(8'h00, 24'hFFFFFF, 3'(c));
        // Mixed patterns.
        for (int n = 0; n < 1500; n++)
            step(8'($urandom), 24'($urandom), 3'($urandom));
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule